// File: doc/BRIEF.md
# Audio DSP Reset and Startup Sequencer

This block sits on the host side of an attached audio DSP. It takes the DSP through a controlled reset and then delivers the DSP's startup messages. A single `start` pulse pulls the DSP reset line low and holds it there for a minimum time. During that time it presents the communication mode pins, then freezes them ahead of the release edge. It then waits a settle period and sends the soft-reset command. After a further application-initialisation wait it sends a programmable list of configuration words.

Every message is a 24-bit word. It leaves the block as three bytes, most significant byte first, on a generic byte write port with a valid/ready handshake. The port can be bridged to any serial or parallel host link. The configuration words live in a small register array that the surrounding logic fills while the sequencer is not busy. The `busy` and `done` outputs report progress.

All waits are counted in clock cycles and derived from a clock-frequency parameter. With the parameters named `CLK_HZ`, `RST_LOW_US`, `SETTLE_US`, `INIT_US` and `INIT_MAX_US`, each cycle count is CLK_HZ·µs/10⁶. In this brief these counts are called RST_CYC, SETTLE_CYC, INIT_CYC and INIT_MAX_CYC. The defaults are a 500 µs settle, a 5 ms initialisation wait and a 10 ms ceiling.

Top module: `dsp_boot_sequencer`

## Requirements
- R1: While `rst_n` is low, `dsp_reset_n`, `busy`, `done` and `wr_valid` are all 0.
- R2: A `start` pulse seen while not busy drives `dsp_reset_n` low from the next cycle, for exactly RST_CYC cycles, and then releases it high.
- R3: `dsp_mode` follows `mode_in` only while `dsp_reset_n` is low. It stays frozen from MODE_SETUP_CYC cycles before the release edge until the next accepted start.
- R4: No byte is offered while `dsp_reset_n` is low. The first `wr_valid` comes exactly SETTLE_CYC cycles after release, and the first word sent is the soft-reset command 0x000001.
- R5: Each word goes out as three bytes: bits 23:16, then 15:8, then 7:0. A byte is consumed only in a cycle where `wr_valid` and `wr_ready` are both 1. While stalled, `wr_valid` and `wr_data` hold.
- R6: After the last soft-reset byte is consumed, the block waits a number of idle cycles before any configuration byte. The wait is INIT_CYC when `init_ovr_en` is 0. Otherwise it is `init_ovr_cyc`, with 0 treated as 1 and values above INIT_MAX_CYC clamped to INIT_MAX_CYC. The wait value is sampled at start.
- R7: The configuration words are then sent from entries 0 up to N−1 in address order. N is `cfg_count` sampled at start, clamped to 16. With N = 0 the block goes to done straight after the wait.
- R8: A write with `cfg_we` high updates entry `cfg_addr` only while `busy` is 0. Writes made while busy leave the array unchanged.
- R9: A `start` pulse while `busy` is 1 has no effect on the running sequence.
- R10: `busy` is 1 from the cycle after an accepted start until the last byte is consumed. `done` then stays 1 until the next start, and the two are never 1 together. A start from done reruns the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full reset-and-configure sequence |
| mode_in | input | MODE_W | Desired communication mode pin values |
| cfg_count | input | CW | Number of configuration words to send (clamped to MAX_WORDS) |
| cfg_we | input | 1 | Configuration array write enable |
| cfg_addr | input | AW | Configuration array write address |
| cfg_wdata | input | 24 | Configuration word to store |
| init_ovr_en | input | 1 | Use `init_ovr_cyc` instead of the default initialisation wait |
| init_ovr_cyc | input | TW | Initialisation wait override, in cycles |
| dsp_reset_n | output | 1 | Active-low reset to the DSP |
| dsp_mode | output | MODE_W | Mode pins to the DSP |
| wr_valid | output | 1 | Byte available on `wr_data` |
| wr_data | output | 8 | Outgoing message byte |
| wr_ready | input | 1 | Write port accepts the byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |

## Verification
The hardest cases to reach from the ports are events that land in the middle of a sequence. These are a start pulse or an array write arriving while the DSP is still in reset or settling, and a write port that stalls between the bytes of one word. The bench fires a start and overwrites entry 0 during the settle phase of one run, then shows in a later run that the old word is still sent. It drives `wr_ready` randomly during a run of sixteen clamped words. It also randomises `mode_in` every cycle, so any sampling outside the allowed window shows up in the per-cycle comparison.

// File: rtl/dsp_boot_sequencer.sv
module dsp_boot_sequencer #(
  parameter int unsigned CLK_HZ         = 250_000_000,
  parameter int unsigned RST_LOW_US     = 2,
  parameter int unsigned MODE_SETUP_CYC = 8,
  parameter int unsigned SETTLE_US      = 500,
  parameter int unsigned INIT_US        = 5000,
  parameter int unsigned INIT_MAX_US    = 10000,
  parameter int unsigned MODE_W         = 3,
  parameter int unsigned MAX_WORDS      = 16,
  localparam int unsigned RST_CYC      = 32'((64'(CLK_HZ) * RST_LOW_US) / 64'd1_000_000),
  localparam int unsigned SETTLE_CYC   = 32'((64'(CLK_HZ) * SETTLE_US) / 64'd1_000_000),
  localparam int unsigned INIT_CYC     = 32'((64'(CLK_HZ) * INIT_US) / 64'd1_000_000),
  localparam int unsigned INIT_MAX_CYC = 32'((64'(CLK_HZ) * INIT_MAX_US) / 64'd1_000_000),
  localparam int unsigned TMAX_A = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC,
  localparam int unsigned TMAX_B = (INIT_MAX_CYC > INIT_CYC) ? INIT_MAX_CYC : INIT_CYC,
  localparam int unsigned TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B,
  localparam int unsigned TW     = $clog2(TMAX + 1),
  localparam int unsigned AW     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int unsigned CW     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [CW-1:0]     cfg_count,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [23:0]       cfg_wdata,
  input  logic              init_ovr_en,
  input  logic [TW-1:0]     init_ovr_cyc,
  output logic              dsp_reset_n,
  output logic [MODE_W-1:0] dsp_mode,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done
);

  localparam logic [23:0] SOFT_RESET_WORD = 24'h000001;

  typedef enum logic [2:0] {
    S_IDLE, S_RLOW, S_SETTLE, S_SOFT, S_INIT, S_CFG, S_DONE
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [TW-1:0] init_r;
  logic [TW-1:0] init_pick;
  logic [CW-1:0] n_r;
  logic [CW-1:0] n_pick;
  logic [AW-1:0] widx;
  logic [1:0]    bidx;
  logic [23:0]   word;
  logic [23:0]   mem [MAX_WORDS];

  assign busy     = (st != S_IDLE) && (st != S_DONE);
  assign done     = (st == S_DONE);
  assign wr_valid = (st == S_SOFT) || (st == S_CFG);
  assign word     = (st == S_CFG) ? mem[widx] : SOFT_RESET_WORD;
  assign wr_data  = (bidx == 2'd0) ? word[23:16] :
                    (bidx == 2'd1) ? word[15:8]  : word[7:0];

  wire xfer     = wr_valid && wr_ready;
  wire start_ok = start && !busy;
  wire last_cfg = (CW'(widx) + 1'b1) == n_r;

  assign n_pick = (32'(cfg_count) > MAX_WORDS) ? CW'(MAX_WORDS) : cfg_count;

  always_comb begin
    if (!init_ovr_en)                         init_pick = TW'(INIT_CYC);
    else if (init_ovr_cyc == '0)              init_pick = TW'(1);
    else if (init_ovr_cyc > TW'(INIT_MAX_CYC)) init_pick = TW'(INIT_MAX_CYC);
    else                                      init_pick = init_ovr_cyc;
  end

  always_ff @(posedge clk)
    if (cfg_we && !busy && (32'(cfg_addr) < MAX_WORDS)) mem[cfg_addr] <= cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tmr         <= '0;
      init_r      <= '0;
      n_r         <= '0;
      widx        <= '0;
      bidx        <= '0;
      dsp_reset_n <= 1'b0;
      dsp_mode    <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start_ok) begin
          st          <= S_RLOW;
          tmr         <= TW'(RST_CYC - 1);
          dsp_reset_n <= 1'b0;
          dsp_mode    <= mode_in;
          init_r      <= init_pick;
          n_r         <= n_pick;
          widx        <= '0;
          bidx        <= '0;
        end
        S_RLOW: begin
          if (tmr >= TW'(MODE_SETUP_CYC)) dsp_mode <= mode_in;
          if (tmr == '0) begin
            dsp_reset_n <= 1'b1;
            st          <= S_SETTLE;
            tmr         <= TW'(SETTLE_CYC - 1);
          end else tmr <= tmr - 1'b1;
        end
        S_SETTLE: if (tmr == '0) st <= S_SOFT; else tmr <= tmr - 1'b1;
        S_SOFT: if (xfer) begin
          if (bidx == 2'd2) begin
            bidx <= '0;
            st   <= S_INIT;
            tmr  <= init_r - 1'b1;
          end else bidx <= bidx + 1'b1;
        end
        S_INIT: begin
          if (tmr == '0) st <= (n_r == '0) ? S_DONE : S_CFG;
          else tmr <= tmr - 1'b1;
        end
        S_CFG: if (xfer) begin
          if (bidx == 2'd2) begin
            bidx <= '0;
            if (last_cfg) st <= S_DONE;
            else widx <= widx + 1'b1;
          end else bidx <= bidx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [TW:0] low_len;
  always_ff @(posedge clk)
    if (!rst_n || dsp_reset_n) low_len <= '0;
    else if (low_len != '1)    low_len <= low_len + 1'b1;

  AST_RESET_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsp_reset_n) |-> (32'(low_len) >= RST_CYC)); // R2
  AST_MODE_FROZEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_reset_n |-> $stable(dsp_mode)); // R3
  AST_MODE_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RLOW && 32'(tmr) < MODE_SETUP_CYC) |=> $stable(dsp_mode)); // R3
  AST_NO_BYTE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> dsp_reset_n); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dsp_reset_n && start) |=> dsp_reset_n); // R9
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R10

endmodule

// File: tb/tb_dsp_boot_sequencer.sv
module tb_dsp_boot_sequencer;
  localparam int HZ = 100_000;
  localparam int L = 10, S = 4, SET = 50, INIT = 500, IMAX = 1000;

  logic clk = 0, rst_n = 0, start = 0, cfg_we = 0, init_ovr_en = 0, wr_ready = 1;
  logic [2:0] mode_in = 0;
  logic [4:0] cfg_count = 0;
  logic [3:0] cfg_addr = 0;
  logic [23:0] cfg_wdata = 0;
  logic [9:0] init_ovr_cyc = 0;
  logic dsp_reset_n, wr_valid, busy, done;
  logic [2:0] dsp_mode;
  logic [7:0] wr_data;

  always #2 clk = ~clk;

  dsp_boot_sequencer #(.CLK_HZ(HZ), .RST_LOW_US(100), .MODE_SETUP_CYC(S), .SETTLE_US(500),
    .INIT_US(5000), .INIT_MAX_US(10000), .MODE_W(3), .MAX_WORDS(16)) dut (
    .clk, .rst_n, .start, .mode_in, .cfg_count, .cfg_we, .cfg_addr, .cfg_wdata,
    .init_ovr_en, .init_ovr_cyc, .dsp_reset_n, .dsp_mode, .wr_valid, .wr_data,
    .wr_ready, .busy, .done);

  int checks = 0, fails = 0;
  bit finished = 0, checking = 0, rdy_rand = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int ph = 0, cnt = 0, m_init = 0, m_n = 0;
  logic [23:0] m_mem [16];
  logic [7:0] q[$];
  logic e_rst = 0;
  logic [2:0] e_mode = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; cnt = 0; e_rst = 0; e_mode = 0; q.delete();
    end else begin
      if (cfg_we && !(ph >= 1 && ph <= 5)) m_mem[cfg_addr] = cfg_wdata;
      case (ph)
        0, 6: if (start) begin
          ph = 1; cnt = L - 1; e_rst = 0; e_mode = mode_in;
          if (!init_ovr_en) m_init = INIT;
          else if (init_ovr_cyc == 0) m_init = 1;
          else if (int'(init_ovr_cyc) > IMAX) m_init = IMAX;
          else m_init = int'(init_ovr_cyc);
          m_n = (cfg_count > 16) ? 16 : int'(cfg_count);
        end
        1: begin
          if (cnt >= S) e_mode = mode_in;
          if (cnt == 0) begin e_rst = 1; ph = 2; cnt = SET - 1; end else cnt--;
        end
        2: if (cnt == 0) begin ph = 3; q = '{8'h00, 8'h00, 8'h01}; end else cnt--;
        3: if (wr_ready) begin
          void'(q.pop_front());
          if (q.size() == 0) begin ph = 4; cnt = m_init - 1; end
        end
        4: if (cnt == 0) begin
          if (m_n == 0) ph = 6;
          else begin
            ph = 5;
            for (int i = 0; i < m_n; i++) begin
              q.push_back(m_mem[i][23:16]); q.push_back(m_mem[i][15:8]); q.push_back(m_mem[i][7:0]);
            end
          end
        end else cnt--;
        5: if (wr_ready) begin
          void'(q.pop_front());
          if (q.size() == 0) ph = 6;
        end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n && checking && !finished) begin
    chk(dsp_reset_n === e_rst, "R2", "dsp_reset_n", 32'(dsp_reset_n), 32'(e_rst));
    chk(dsp_mode === e_mode, "R3", "dsp_mode", 32'(dsp_mode), 32'(e_mode));
    chk(wr_valid === (ph == 3 || ph == 5), (ph == 4) ? "R6" : "R4", "wr_valid",
        32'(wr_valid), 32'(ph == 3 || ph == 5));
    if (ph == 3 || ph == 5) chk(wr_data === q[0], "R5", "wr_data", 32'(wr_data), 32'(q[0]));
    chk(busy === (ph >= 1 && ph <= 5), "R10", "busy", 32'(busy), 32'(ph >= 1 && ph <= 5));
    chk(done === (ph == 6), "R10", "done", 32'(done), 32'(ph == 6));
  end

  logic [7:0] got[$];
  always @(negedge clk) if (rst_n && wr_valid && wr_ready) got.push_back(wr_data);
  always @(negedge clk) mode_in <= 3'($urandom_range(0, 7));
  always @(posedge clk) #1 wr_ready <= rdy_rand ? 1'($urandom_range(0, 1)) : 1'b1;

  logic [23:0] tb_mem [16];
  int bcnt;

  task automatic write_cfg(input int a, input logic [23:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run(input int n, input bit ovr, input int ovr_v);
    got.delete();
    @(negedge clk);
    cfg_count = 5'(n); init_ovr_en = ovr; init_ovr_cyc = 10'(ovr_v); start = 1;
    @(negedge clk); start = 0;
    bcnt = 0;
    for (int t = 0; t < 20000; t++) begin
      if (busy) bcnt++;
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic check_words(input logic [23:0] w[$], input string req);
    chk(got.size() == 3 * w.size(), req, "byte count", 32'(got.size()), 32'(3 * w.size()));
    for (int i = 0; i < w.size() && 3 * i + 2 < got.size(); i++)
      chk({got[3*i], got[3*i+1], got[3*i+2]} === w[i], req, "word", 
          32'({got[3*i], got[3*i+1], got[3*i+2]}), 32'(w[i]));
  endtask

  initial begin
    logic [23:0] ew[$];
    repeat (4) @(negedge clk);
    chk(dsp_reset_n === 0 && busy === 0 && done === 0 && wr_valid === 0, "R1", "reset outputs",
        {28'd0, dsp_reset_n, busy, done, wr_valid}, 32'd0);
    rst_n = 1; checking = 1;
    for (int i = 0; i < 16; i++) begin
      tb_mem[i] = 24'h100000 * (i + 1) + 24'h000111 * i;
      write_cfg(i, tb_mem[i]);
    end

    // run 1: three words, with a start pulse and an array write while busy
    fork
      run(3, 0, 0);
      begin
        repeat (30) @(negedge clk);
        start = 1; @(negedge clk); start = 0;  // R9 ignored start
        write_cfg(0, 24'hDEAD00);               // R8 ignored write
      end
    join
    ew = '{24'h000001, tb_mem[0], tb_mem[1], tb_mem[2]};
    check_words(ew, "R7");
    chk(bcnt == L + SET + 3 + INIT + 9, "R9", "busy cycles with stray start", 32'(bcnt),
        32'(L + SET + 3 + INIT + 9));
    chk(done === 1 && busy === 0, "R10", "done held", {30'd0, done, busy}, 32'd2);

    // run 2: restart from done, zero words, short override
    run(0, 1, 7);
    ew = '{24'h000001};
    check_words(ew, "R7");
    chk(bcnt == L + SET + 3 + 7, "R6", "override wait busy cycles", 32'(bcnt), 32'(L + SET + 10));

    // run 3: count clamped to 16, override clamped, random stalls
    rdy_rand = 1;
    run(20, 1, 1023);
    rdy_rand = 0;
    ew = '{24'h000001};
    for (int i = 0; i < 16; i++) ew.push_back(tb_mem[i]);
    check_words(ew, "R7");
    if (got.size() >= 6)
      chk({got[3], got[4], got[5]} === tb_mem[0], "R8", "entry 0 after busy write",
          32'({got[3], got[4], got[5]}), 32'(tb_mem[0]));

    // run 4: override of zero treated as one
    run(1, 1, 0);
    ew = '{24'h000001, tb_mem[0]};
    check_words(ew, "R7");
    chk(bcnt == L + SET + 3 + 1 + 3, "R6", "zero override busy cycles", 32'(bcnt), 32'(L + SET + 7));

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R10: watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule